// File: doc/BRIEF.md
# Interleaved Multi-Word Instruction Fetch Memory

This block is a read-only instruction store for a wide front end that needs several consecutive instruction words in one cycle. Words are spread across LANES banks. Word address `a` lives in bank `a mod LANES`, at row `a div LANES`. Because of this placement, any run of LANES consecutive words touches each bank exactly once. A read can therefore start at any word address, aligned to a row or not, and still complete in a single access.

For a request, each bank gets its own row. A bank whose index is below the start offset reads the row after the base row. Every other bank reads the base row itself. A rotation network then puts the bank outputs into program order, so output slot `k` holds word `a + k`. The result and a valid flag are registered, one cycle after the request. Addresses past the end of the store wrap to word 0.

Initial contents come in through a one-word load port, which only the testbench drives.

Top module: `ifetch_bank_mem`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `rd_valid` = 0 and `rd_words` = 0.
- R2: `rd_valid` is 1 in the cycle after an edge where `rd_req` was 1, and 0 after an edge where `rd_req` was 0.
- R3: A read at a start address with offset 0 (`rd_addr mod LANES` = 0) returns words a, a+1, …, a+LANES-1. Slot k is in bits [32k+31:32k] of `rd_words`.
- R4: A read at any nonzero offset returns the same program-ordered sequence, one word per slot. It is never a rotated copy of it.
- R5: In an unaligned read, the banks below the offset supply words from the next row. For example, start 5 with LANES=4 yields 5, 6, 7, 8.
- R6: A read whose window runs past the last word wraps modulo DEPTH_WORDS. For example, start 62 with depth 64 yields 62, 63, 0, 1.
- R7: A load with `ld_en` = 1 stores `ld_data` at word `ld_addr`. Reads issued after that edge return the new value.
- R8: When a read and a load fall on the same edge, the read returns the word as it was before the load.
- R9: After an edge with `rd_req` = 0, `rd_words` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | AW | Start word address of the read |
| ld_en | input | 1 | Load strobe for one word |
| ld_addr | input | AW | Word address of the load |
| ld_data | input | 32 | Word to store |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_words | output | LANES*32 | Words in program order; slot k at [32k+31:32k] |

## Verification
A read and a load can land on the same edge. The bench provokes this by loading a new value into the second word of a pending read window during the read cycle itself. That read must return the old word (R8). A read issued straight afterwards must return the new word (R7). Row crossing and end-of-memory wrap are judged against a flat reference array, covering every offset within a row and the last addresses of the store.

// File: rtl/ifm_pkg.sv
// Package: shared word type for the interleaved fetch memory.
// Assumes instruction words are 32 bits wide.
package ifm_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifm_row_gen.sv
// Module: ifm_row_gen
// Works out the row each bank reads for a given start word address.
// Banks below the start offset read the next row; the row count wraps.
// Assumes LANES and the row count are powers of two.
module ifm_row_gen #(
    parameter int LANES = 4,
    parameter int AW    = 6,
    localparam int LB   = $clog2(LANES),
    localparam int RW   = AW - LB
) (
    input  logic [AW-1:0] start_addr,
    output logic [RW-1:0] bank_row [LANES]
);
    logic [LB-1:0] offset;
    logic [RW-1:0] base_row;

    assign offset   = start_addr[LB-1:0];
    assign base_row = start_addr[AW-1:LB];

    // Pick base or next row for each bank from its position relative to the offset.
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            bank_row[b] = (LB'(b) < offset) ? base_row + RW'(1) : base_row;
        end
    end

    // The highest bank never lies below the offset, so it always reads the base row.
    always_comb begin
        a_r5_top_bank_base: assert (bank_row[LANES-1] == start_addr[AW-1:LB]);
    end
endmodule

// File: rtl/ifm_bank.sv
// Module: ifm_bank
// One word-wide bank of the store. It has a combinational read at rd_row and
// a clocked write at wr_row. Contents are not reset; they come from the load port.
module ifm_bank #(
    parameter int RW = 4,
    localparam int ROWS = 1 << RW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  ifm_pkg::word_t wr_data,
    input  logic [RW-1:0] rd_row,
    output ifm_pkg::word_t rd_data
);
    ifm_pkg::word_t store [ROWS];

    // Write one row on a load.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_row] <= wr_data;
    end

    // Read the addressed row without a clock.
    assign rd_data = store[rd_row];
endmodule

// File: rtl/ifm_rotator.sv
// Module: ifm_rotator
// Puts raw bank outputs into program order.
// Output slot k takes the word from bank (offset + k) mod LANES.
// Assumes LANES is a power of two, so the wrap is a plain truncation.
module ifm_rotator #(
    parameter int LANES = 4,
    localparam int LB   = $clog2(LANES)
) (
    input  logic [LB-1:0]   offset,
    input  ifm_pkg::word_t  bank_word [LANES],
    output ifm_pkg::word_t  slot_word [LANES]
);
    for (genvar k = 0; k < LANES; k++) begin : g_slot
        logic [LB-1:0] src;
        // Select the source bank for this slot.
        assign src          = offset + LB'(k);
        assign slot_word[k] = bank_word[src];
    end
endmodule

// File: rtl/ifetch_bank_mem.sv
// Module: ifetch_bank_mem (top)
// Instruction store that returns LANES consecutive words from any start address
// with one cycle of latency. Words are interleaved across LANES banks.
// Assumes LANES >= 2, and that LANES and DEPTH_WORDS are powers of two.
// A read on the same edge as a load sees the contents from before the load.
module ifetch_bank_mem #(
    parameter int LANES       = 4,
    parameter int DEPTH_WORDS = 64,
    localparam int AW         = $clog2(DEPTH_WORDS),
    localparam int LB         = $clog2(LANES),
    localparam int RW         = AW - LB,
    localparam int W          = ifm_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    input  logic               ld_en,
    input  logic [AW-1:0]      ld_addr,
    input  logic [W-1:0]       ld_data,
    output logic               rd_valid,
    output logic [LANES*W-1:0] rd_words
);
    initial begin
        a_param_shape: assert (LANES >= 2 && (1 << LB) == LANES && (1 << AW) == DEPTH_WORDS
                               && DEPTH_WORDS >= LANES);
    end

    logic [RW-1:0]  bank_row  [LANES];
    ifm_pkg::word_t bank_word [LANES];
    ifm_pkg::word_t slot_word [LANES];
    logic [LANES*W-1:0] slot_flat;

    ifm_row_gen #(.LANES(LANES), .AW(AW)) u_rows (
        .start_addr (rd_addr),
        .bank_row   (bank_row)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic hit;
        // Steer a load to the bank that owns its low address bits.
        assign hit = ld_en && (ld_addr[LB-1:0] == LB'(b));
        ifm_bank #(.RW(RW)) u_bank (
            .clk     (clk),
            .wr_en   (hit),
            .wr_row  (ld_addr[AW-1:LB]),
            .wr_data (ld_data),
            .rd_row  (bank_row[b]),
            .rd_data (bank_word[b])
        );
    end

    ifm_rotator #(.LANES(LANES)) u_rot (
        .offset    (rd_addr[LB-1:0]),
        .bank_word (bank_word),
        .slot_word (slot_word)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_flat
        assign slot_flat[k*W +: W] = slot_word[k];
    end

    // Register the ordered words and the valid flag; hold the words when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_words <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_words <= slot_flat;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_words == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_words));
endmodule

// File: tb/ifetch_bank_mem_test.sv
module ifetch_bank_mem_test;
    localparam int LANES  = 4;
    localparam int DEPTH  = 64;
    localparam int AW     = 6;
    localparam int PERIOD = 10;
    localparam int NVEC   = 12;
    localparam int VEC_ADDR [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7, 13, 60, 62, 63};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic rd_valid;
    logic [LANES*32-1:0] rd_words;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] ref_mem [DEPTH];

    ifetch_bank_mem #(.LANES(LANES), .DEPTH_WORDS(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_valid(rd_valid), .rd_words(rd_words)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pattern(int i);
        return {8'hC3, 8'(i), 16'(i * 37 + 5)};
    endfunction

    task automatic expect_bit(string tag, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic expect_window(string tag, int a);
        bit bad = 1'b0;
        n_checks++;
        for (int k = 0; k < LANES; k++) begin
            logic [31:0] exp = ref_mem[(a + k) % DEPTH];
            logic [31:0] got = rd_words[k*32 +: 32];
            if (got !== exp && !bad) begin
                bad = 1'b1;
                n_fail++;
                $display("FAIL %s: start %0d slot %0d got %h expected %h", tag, a, k, got, exp);
            end
        end
    endtask

    task automatic load_word(int a, logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic issue_read(int a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [LANES*32-1:0] held;
        // R1: reset state
        @(negedge clk); @(negedge clk);
        expect_bit("R1 valid", rd_valid, 1'b0);
        n_checks++;
        if (rd_words !== '0) begin
            n_fail++;
            $display("FAIL R1 words: got %h expected 0", rd_words);
        end
        rst_n = 1'b1;

        for (int i = 0; i < DEPTH; i++) load_word(i, pattern(i));

        // Table walk: offset 0 -> R3, inside the row -> R4/R5, past the end -> R6
        for (int v = 0; v < NVEC; v++) begin
            int a = VEC_ADDR[v];
            string tag;
            if (a + LANES > DEPTH)          tag = "R6 wrap";
            else if (a % LANES == 0)        tag = "R3 aligned";
            else                            tag = "R4 R5 unaligned";
            issue_read(a);
            expect_bit("R2 valid", rd_valid, 1'b1);
            expect_window(tag, a);
        end

        // R9: idle cycle keeps the words; R2: valid drops
        held = rd_words;
        @(negedge clk);
        expect_bit("R2 idle valid", rd_valid, 1'b0);
        n_checks++;
        if (rd_words !== held) begin
            n_fail++;
            $display("FAIL R9 hold: got %h expected %h", rd_words, held);
        end

        // R8: load into word 9 on the same edge as a read starting at 8
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(8);
        ld_en = 1'b1; ld_addr = AW'(9); ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        rd_req = 1'b0; ld_en = 1'b0;
        expect_window("R8 read-before-load", 8);
        ref_mem[9] = 32'hDEAD_BEEF;

        // R7: the new word shows up in the next read
        issue_read(7);
        expect_window("R7 load visible", 7);

        // R1: reset again mid-run with a request pending
        @(negedge clk);
        rst_n = 1'b0; rd_req = 1'b1; rd_addr = AW'(3);
        @(negedge clk);
        rd_req = 1'b0;
        expect_bit("R1 re-reset valid", rd_valid, 1'b0);
        n_checks++;
        if (rd_words !== '0) begin
            n_fail++;
            $display("FAIL R1 re-reset words: got %h expected 0", rd_words);
        end
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule